// File: doc/BRIEF.md
# Network controller detection sequencer

After reset this block works out which of three network controller families is attached to an SPI access engine. It then configures buffer sizing and publishes the register block base and per-socket transmit and receive buffer bases. It moves nothing over the link itself. It drives single-byte register reads and writes through a request/acknowledge port and presents a family-select code so that the engine frames each access correctly. The code shows the family under test during a probe and the identified family afterwards.

The probes run in a fixed order. The family that cannot recover its serial state after chip-select is released is probed first, so that the other framings cannot wedge it. Each probe begins with a soft reset. It then runs a write-and-read-back pattern on the mode register and, for two of the families, checks a version register. Once the search has ended and a family was found, a helper issues socket commands. It writes the command register and polls it until the device clears it, and it flags an error if the poll limit runs out.

Top module: `netctl_probe`

## Requirements
- R1: No bus request is raised until `STARTUP_CYC` clock cycles have passed since reset was released.
- R2: Probes run in the order framed family (type code 2), block family (code 3), legacy family (code 1), and `fam_sel` carries the code of the family under test on every probe access.
- R3: Each probe starts by writing 0x80 to the mode register at address 0x0000, then reads that address until it returns 0. At most `RST_POLLS` reads are made, spaced at least `POLL_GAP_CYC` cycles apart, and a register that never clears ends that probe as a miss.
- R4: Framed and block probes write 0x08, 0x10 and 0x00 to address 0x0000, each followed by a read of the same address. A read-back that differs from the value written ends the probe as a miss at once.
- R5: A framed probe then reads address 0x001F and needs the value 3. A block probe reads address 0x0039 and needs the value 4.
- R6: A legacy probe writes and reads back 0x10, 0x12 and 0x00 at address 0x0000 and reads no version register.
- R7: On a framed match the register base is 0x4000, transmit base 0x8000, receive base 0xC000, size 2048 and mask 0x07FF. For each slot s from 0 to 7 in turn, the block writes the receive-size register at 0x4000+s*0x100+0x1E and then the transmit-size register at +0x1F. Each is written with 2 when s < `NUM_SOCK` and with 0 otherwise.
- R8: On a block match the register base is 0x1000, the buffer bases are 0x8000 and 0xC000 with 2048-byte sizing, and no configuration writes follow.
- R9: On a legacy match the register base is 0x0400, the transmit base 0x4000, the receive base 0x6000 and the size 2048. The block writes 0x55 to address 0x001B and then 0x55 to address 0x001A.
- R10: When all three probes miss, `det_done` is set with `det_found` low, type code 0, and every base, size and mask output 0. The done state holds until the next reset.
- R11: Socket i has transmit base equal to the transmit base plus size*i, and receive base equal to the receive base plus size*i. Socket i occupies bits [16i+15:16i] of each flat base output.
- R12: A command writes `cmd_code` to register base + socket*0x100 + 0x01, then reads that address until it returns 0. `cmd_done` pulses for one cycle with `cmd_err` low.
- R13: If `CMD_POLLS` reads in a row return nonzero, the command ends with `cmd_done` and `cmd_err` pulsing together and no further reads are made.
- R14: `cmd_valid` is ignored, with no bus access and no change to `cmd_busy`, until a family has been found, and also while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | One-cycle completion of the pending access |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| fam_sel | output | 2 | Framing family for the engine (0 none, 1 legacy, 2 framed, 3 block) |
| det_done | output | 1 | Search finished |
| det_found | output | 1 | A family was identified |
| det_type | output | 2 | Identified family code |
| reg_base | output | 16 | Register block base |
| buf_size | output | 16 | Per-socket buffer size in bytes |
| buf_mask | output | 16 | Buffer offset mask |
| tx_base_flat | output | 16*NUM_SOCK | Per-socket transmit buffer bases |
| rx_base_flat | output | 16*NUM_SOCK | Per-socket receive buffer bases |
| cmd_valid | input | 1 | Start a socket command |
| cmd_sock | input | SOCK_W | Target socket |
| cmd_code | input | 8 | Command byte |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | Command finished (pulse) |
| cmd_err | output | 1 | Command poll timed out (pulse) |

## Verification
The search is run against four emulated devices, and each one ends it at a different point. A framed-family device with a fast reset matches on the first probe and exercises the sixteen slot-sizing writes. A block-family device with a slow soft reset passes the pattern of the framed probe but fails its version read, which shows that the version check is what separates the two. A legacy device that cannot hold mode bit 3 fails the read-back of both earlier probes and then matches, which exercises early rejection and the legacy memory writes. An absent device that returns 0xFF on every read tests the poll limit, the poll spacing and the not-found outputs. Commands are tried with a register that clears after a few reads and with one that never clears, and extra requests are made before detection ends and during a busy command.

// File: rtl/netctl_probe_pkg.sv
package netctl_probe_pkg;

    typedef enum logic [1:0] {
        FAM_NONE   = 2'd0,
        FAM_LEGACY = 2'd1,
        FAM_FRAMED = 2'd2,
        FAM_BLOCK  = 2'd3
    } fam_e;

    typedef struct packed {
        logic [15:0] regs;
        logic [15:0] tx;
        logic [15:0] rx;
        logic [15:0] size;
    } layout_t;

    localparam logic [15:0] MODE_ADDR      = 16'h0000;
    localparam logic [7:0]  SOFT_RST_VAL   = 8'h80;
    localparam logic [15:0] VER_ADDR_FRM   = 16'h001F;
    localparam logic [15:0] VER_ADDR_BLK   = 16'h0039;
    localparam logic [7:0]  VER_VAL_FRM    = 8'd3;
    localparam logic [7:0]  VER_VAL_BLK    = 8'd4;
    localparam logic [7:0]  RXSZ_OFF       = 8'h1E;
    localparam logic [7:0]  TXSZ_OFF       = 8'h1F;
    localparam logic [7:0]  CMD_OFF        = 8'h01;
    localparam logic [15:0] LEG_TXMEM_ADDR = 16'h001B;
    localparam logic [15:0] LEG_RXMEM_ADDR = 16'h001A;
    localparam logic [7:0]  LEG_MEM_VAL    = 8'h55;

    // Fixed search order: fragile framed family first, legacy last.
    function automatic fam_e probe_fam(input logic [1:0] idx);
        case (idx)
            2'd0:    return FAM_FRAMED;
            2'd1:    return FAM_BLOCK;
            default: return FAM_LEGACY;
        endcase
    endfunction

    function automatic logic [7:0] probe_pat(input fam_e f, input logic [1:0] i);
        if (f == FAM_LEGACY)
            return (i == 2'd0) ? 8'h10 : (i == 2'd1) ? 8'h12 : 8'h00;
        return (i == 2'd0) ? 8'h08 : (i == 2'd1) ? 8'h10 : 8'h00;
    endfunction

    function automatic logic [15:0] fam_regs(input fam_e f);
        case (f)
            FAM_FRAMED: return 16'h4000;
            FAM_BLOCK:  return 16'h1000;
            FAM_LEGACY: return 16'h0400;
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic layout_t fam_layout(input fam_e f);
        layout_t l;
        l.regs = fam_regs(f);
        l.size = (f == FAM_NONE) ? 16'h0000 : 16'd2048;
        case (f)
            FAM_LEGACY: begin l.tx = 16'h4000; l.rx = 16'h6000; end
            FAM_NONE:   begin l.tx = 16'h0000; l.rx = 16'h0000; end
            default:    begin l.tx = 16'h8000; l.rx = 16'hC000; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/netctl_probe_fsm.sv
module netctl_probe_fsm
    import netctl_probe_pkg::*;
#(
    parameter int STARTUP_CYC  = 140_000_000,
    parameter int POLL_GAP_CYC = 250_000,
    parameter int RST_POLLS    = 20,
    parameter int NUM_SOCK     = 4,
    parameter int SLOTS        = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ack,
    input  logic [7:0]  rdata,
    output logic        req,
    output logic        we,
    output logic [15:0] addr,
    output logic [7:0]  wdata,
    output fam_e        cur_fam,
    output logic        done,
    output logic        found,
    output fam_e        det_fam
);
    localparam int TMAX = (STARTUP_CYC > POLL_GAP_CYC) ? STARTUP_CYC : POLL_GAP_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(RST_POLLS + 1);
    localparam int CFGN = 2 * SLOTS;
    localparam int CW   = $clog2(CFGN + 1);
    localparam logic [7:0] SZ_CODE = 8'd2;  // 2048 >> 10

    typedef enum logic [3:0] {
        S_WAIT, S_RST_WR, S_RST_RD, S_RST_GAP, S_PAT_WR,
        S_PAT_RD, S_VER_RD, S_CFG_WR, S_DONE
    } st_e;

    st_e         state;
    logic [TW-1:0] timer;
    logic [1:0]  probe_idx, pat_idx;
    logic [PW-1:0] polls;
    logic [CW-1:0] cfg_idx;
    fam_e        pfam;
    logic [CW-1:0] cfg_n;
    logic [CW-2:0] slot;
    logic        fail, pass;

    assign pfam    = probe_fam(probe_idx);
    assign cur_fam = done ? det_fam : pfam;
    assign cfg_n   = (pfam == FAM_FRAMED) ? CW'(CFGN) : (pfam == FAM_LEGACY) ? CW'(2) : '0;
    assign slot    = cfg_idx[CW-1:1];

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = MODE_ADDR;
        wdata = 8'h00;
        case (state)
            S_RST_WR: begin req = 1'b1; we = 1'b1; wdata = SOFT_RST_VAL; end
            S_RST_RD, S_PAT_RD: req = 1'b1;
            S_PAT_WR: begin req = 1'b1; we = 1'b1; wdata = probe_pat(pfam, pat_idx); end
            S_VER_RD: begin
                req  = 1'b1;
                addr = (pfam == FAM_FRAMED) ? VER_ADDR_FRM : VER_ADDR_BLK;
            end
            S_CFG_WR: begin
                req = 1'b1;
                we  = 1'b1;
                if (pfam == FAM_LEGACY) begin
                    addr  = cfg_idx[0] ? LEG_RXMEM_ADDR : LEG_TXMEM_ADDR;
                    wdata = LEG_MEM_VAL;
                end else begin
                    addr  = fam_regs(pfam) + {5'(slot), 8'h00}
                            + {8'h00, (cfg_idx[0] ? TXSZ_OFF : RXSZ_OFF)};
                    wdata = (32'(slot) < NUM_SOCK) ? SZ_CODE : 8'h00;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        fail = 1'b0;
        pass = 1'b0;
        if (ack) begin
            case (state)
                S_RST_RD: fail = (rdata != 8'h00) && (polls == PW'(RST_POLLS - 1));
                S_PAT_RD: begin
                    fail = (rdata != probe_pat(pfam, pat_idx));
                    pass = !fail && (pat_idx == 2'd2) && (pfam == FAM_LEGACY);
                end
                S_VER_RD: begin
                    pass = (rdata == ((pfam == FAM_FRAMED) ? VER_VAL_FRM : VER_VAL_BLK));
                    fail = !pass;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_WAIT;
            timer     <= '0;
            probe_idx <= 2'd0;
            pat_idx   <= 2'd0;
            polls     <= '0;
            cfg_idx   <= '0;
            done      <= 1'b0;
            found     <= 1'b0;
            det_fam   <= FAM_NONE;
        end else if (fail) begin
            if (probe_idx == 2'd2) begin
                state <= S_DONE;
                done  <= 1'b1;
            end else begin
                probe_idx <= probe_idx + 2'd1;
                state     <= S_RST_WR;
            end
        end else if (pass) begin
            if (cfg_n == '0) begin
                state   <= S_DONE;
                done    <= 1'b1;
                found   <= 1'b1;
                det_fam <= pfam;
            end else begin
                cfg_idx <= '0;
                state   <= S_CFG_WR;
            end
        end else begin
            case (state)
                S_WAIT: begin
                    timer <= timer + 1'b1;
                    if (timer == TW'(STARTUP_CYC - 1)) state <= S_RST_WR;
                end
                S_RST_WR: if (ack) begin polls <= '0; state <= S_RST_RD; end
                S_RST_RD: if (ack) begin
                    if (rdata == 8'h00) begin
                        pat_idx <= 2'd0;
                        state   <= S_PAT_WR;
                    end else begin
                        polls <= polls + 1'b1;
                        timer <= '0;
                        state <= S_RST_GAP;
                    end
                end
                S_RST_GAP: begin
                    timer <= timer + 1'b1;
                    if (timer == TW'(POLL_GAP_CYC - 1)) state <= S_RST_RD;
                end
                S_PAT_WR: if (ack) state <= S_PAT_RD;
                S_PAT_RD: if (ack) begin
                    if (pat_idx == 2'd2) state <= S_VER_RD;
                    else begin
                        pat_idx <= pat_idx + 2'd1;
                        state   <= S_PAT_WR;
                    end
                end
                S_CFG_WR: if (ack) begin
                    if (cfg_idx == cfg_n - 1'b1) begin
                        state   <= S_DONE;
                        done    <= 1'b1;
                        found   <= 1'b1;
                        det_fam <= pfam;
                    end else cfg_idx <= cfg_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R10: once finished, the result is frozen until reset
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(det_fam) && $stable(found));
    // R2: a found result always carries a nonzero family code
    p_found_type_r2: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (det_fam != FAM_NONE));
    // R3: a soft-reset poll never exceeds its limit
    p_poll_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_RST_RD) |-> (32'(polls) < RST_POLLS));
endmodule

// File: rtl/netctl_base_gen.sv
module netctl_base_gen
    import netctl_probe_pkg::*;
#(
    parameter int NUM_SOCK = 4
) (
    input  logic                   found,
    input  fam_e                   fam,
    output logic [15:0]            reg_base,
    output logic [15:0]            buf_size,
    output logic [15:0]            buf_mask,
    output logic [16*NUM_SOCK-1:0] tx_flat,
    output logic [16*NUM_SOCK-1:0] rx_flat
);
    layout_t lay;

    assign lay      = fam_layout(found ? fam : FAM_NONE);
    assign reg_base = lay.regs;
    assign buf_size = lay.size;
    assign buf_mask = found ? (lay.size - 16'd1) : 16'h0000;

    for (genvar i = 0; i < NUM_SOCK; i++) begin : g_sock
        assign tx_flat[16*i +: 16] = found ? (lay.tx + 16'(lay.size * i)) : 16'h0000;
        assign rx_flat[16*i +: 16] = found ? (lay.rx + 16'(lay.size * i)) : 16'h0000;
    end
endmodule

// File: rtl/netctl_cmd_issuer.sv
module netctl_cmd_issuer
    import netctl_probe_pkg::*;
#(
    parameter int CMD_POLLS = 1000,
    parameter int SOCK_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [15:0]       reg_base,
    input  logic              cmd_valid,
    input  logic [SOCK_W-1:0] cmd_sock,
    input  logic [7:0]        cmd_code,
    input  logic              ack,
    input  logic [7:0]        rdata,
    output logic              req,
    output logic              we,
    output logic [15:0]       addr,
    output logic [7:0]        wdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int NW = $clog2(CMD_POLLS + 1);

    typedef enum logic [1:0] {C_IDLE, C_WR, C_RD} cst_e;

    cst_e        state;
    logic [15:0] tgt;
    logic [7:0]  code;
    logic [NW-1:0] polls;

    assign busy  = (state != C_IDLE);
    assign req   = busy;
    assign we    = (state == C_WR);
    assign addr  = tgt;
    assign wdata = code;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= C_IDLE;
            tgt   <= '0;
            code  <= '0;
            polls <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                C_IDLE: if (cmd_valid && enable) begin
                    tgt   <= reg_base + {(16 - 8 - SOCK_W)'(0), cmd_sock, 8'h00} + {8'h00, CMD_OFF};
                    code  <= cmd_code;
                    polls <= '0;
                    state <= C_WR;
                end
                C_WR: if (ack) state <= C_RD;
                C_RD: if (ack) begin
                    if (rdata == 8'h00) begin
                        done  <= 1'b1;
                        state <= C_IDLE;
                    end else if (polls == NW'(CMD_POLLS - 1)) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= C_IDLE;
                    end else polls <= polls + 1'b1;
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    // R13: a timeout is always reported as a completion too
    p_err_done_r13: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    // R14: without a detected family no command starts
    p_idle_gate_r14: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !busy);
endmodule

// File: rtl/netctl_probe.sv
module netctl_probe
    import netctl_probe_pkg::*;
#(
    parameter int STARTUP_CYC  = 140_000_000,
    parameter int POLL_GAP_CYC = 250_000,
    parameter int RST_POLLS    = 20,
    parameter int CMD_POLLS    = 1000,
    parameter int NUM_SOCK     = 4,
    parameter int SLOTS        = 8,
    localparam int SOCK_W      = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [15:0]            bus_addr,
    output logic [7:0]             bus_wdata,
    input  logic                   bus_ack,
    input  logic [7:0]             bus_rdata,
    output logic [1:0]             fam_sel,
    output logic                   det_done,
    output logic                   det_found,
    output logic [1:0]             det_type,
    output logic [15:0]            reg_base,
    output logic [15:0]            buf_size,
    output logic [15:0]            buf_mask,
    output logic [16*NUM_SOCK-1:0] tx_base_flat,
    output logic [16*NUM_SOCK-1:0] rx_base_flat,
    input  logic                   cmd_valid,
    input  logic [SOCK_W-1:0]      cmd_sock,
    input  logic [7:0]             cmd_code,
    output logic                   cmd_busy,
    output logic                   cmd_done,
    output logic                   cmd_err
);
    localparam int WW = $clog2(STARTUP_CYC + 1);

    logic        p_req, p_we, c_req, c_we;
    logic [15:0] p_addr, c_addr;
    logic [7:0]  p_wdata, c_wdata;
    fam_e        cur_fam, det_fam;
    logic        found;

    netctl_probe_fsm #(
        .STARTUP_CYC(STARTUP_CYC), .POLL_GAP_CYC(POLL_GAP_CYC),
        .RST_POLLS(RST_POLLS), .NUM_SOCK(NUM_SOCK), .SLOTS(SLOTS)
    ) u_fsm (
        .clk(clk), .rst(rst), .ack(bus_ack && !det_done), .rdata(bus_rdata),
        .req(p_req), .we(p_we), .addr(p_addr), .wdata(p_wdata),
        .cur_fam(cur_fam), .done(det_done), .found(found), .det_fam(det_fam)
    );

    netctl_base_gen #(.NUM_SOCK(NUM_SOCK)) u_bases (
        .found(found), .fam(det_fam), .reg_base(reg_base),
        .buf_size(buf_size), .buf_mask(buf_mask),
        .tx_flat(tx_base_flat), .rx_flat(rx_base_flat)
    );

    netctl_cmd_issuer #(.CMD_POLLS(CMD_POLLS), .SOCK_W(SOCK_W)) u_cmd (
        .clk(clk), .rst(rst), .enable(found), .reg_base(reg_base),
        .cmd_valid(cmd_valid), .cmd_sock(cmd_sock), .cmd_code(cmd_code),
        .ack(bus_ack && det_done), .rdata(bus_rdata),
        .req(c_req), .we(c_we), .addr(c_addr), .wdata(c_wdata),
        .busy(cmd_busy), .done(cmd_done), .err(cmd_err)
    );

    // Detector owns the port until its search ends, then the issuer.
    assign bus_req   = det_done ? c_req   : p_req;
    assign bus_we    = det_done ? c_we    : p_we;
    assign bus_addr  = det_done ? c_addr  : p_addr;
    assign bus_wdata = det_done ? c_wdata : p_wdata;
    assign fam_sel   = cur_fam;
    assign det_found = found;
    assign det_type  = det_fam;

    logic [WW-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != WW'(STARTUP_CYC)) since_rst <= since_rst + 1'b1;
    end

    // R1: the port stays quiet through the start-up wait
    p_quiet_start_r1: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (since_rst == WW'(STARTUP_CYC)));
    // R3: a pending access keeps its address and direction until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we));
    // R10: a failed search leaves every layout output at zero
    p_none_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (det_done && !det_found) |-> (det_type == 2'd0 && reg_base == 16'h0 && buf_size == 16'h0));
endmodule

// File: tb/netctl_probe_tb_top.sv
module netctl_probe_tb_top;
    localparam int STARTUP = 50;
    localparam int GAP     = 10;
    localparam int RPOLLS  = 20;
    localparam int CPOLLS  = 6;
    localparam int NS      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [1:0]  fam_sel, det_type;
    logic        det_done, det_found;
    logic [15:0] reg_base, buf_size, buf_mask;
    logic [16*NS-1:0] tx_flat, rx_flat;
    logic        cmd_valid, cmd_busy, cmd_done, cmd_err;
    logic [1:0]  cmd_sock;
    logic [7:0]  cmd_code;

    netctl_probe #(
        .STARTUP_CYC(STARTUP), .POLL_GAP_CYC(GAP), .RST_POLLS(RPOLLS),
        .CMD_POLLS(CPOLLS), .NUM_SOCK(NS), .SLOTS(8)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .fam_sel(fam_sel), .det_done(det_done),
        .det_found(det_found), .det_type(det_type), .reg_base(reg_base),
        .buf_size(buf_size), .buf_mask(buf_mask), .tx_base_flat(tx_flat),
        .rx_base_flat(rx_flat), .cmd_valid(cmd_valid), .cmd_sock(cmd_sock),
        .cmd_code(cmd_code), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .cmd_err(cmd_err)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [1:0]  fam;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // emulated device
    int dev = 0, rst_slow = 0, cmd_reads = 0;
    logic [7:0] mode_mask = 8'hFF, mode_val = 8'h00, cmd_val = 8'h00;
    int rst_cnt = 0, cmd_left = 0;
    int rd0_n = 0, rd0_first = 0, rd0_20 = 0, first_req = -1, rel_cyc = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push(input bit w, input logic [15:0] a, input logic [7:0] d, input logic [1:0] f);
        exp_t e;
        e.we = w; e.addr = a; e.wd = w ? d : 8'h00; e.fam = f;
        q.push_back(e);
    endtask

    // monitor + responder
    always @(negedge clk) begin
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            exp_t got, e;
            got.we = bus_we; got.addr = bus_addr; got.wd = bus_we ? bus_wdata : 8'h00; got.fam = fam_sel;
            if (first_req < 0) first_req = cyc;
            if (q.size() == 0) chk(1'b0, "R2/R14 unexpected access", 64'(got), 64'h0);
            else begin
                e = q.pop_front();
                chk(got == e, "R2-sequence access", 64'(got), 64'(e));
            end
            bus_rdata = 8'h00;
            if (dev == 0) bus_rdata = 8'hFF;
            else if (bus_we) begin
                if (bus_addr == 16'h0000) begin
                    if (bus_wdata == 8'h80) begin rst_cnt = rst_slow; mode_val = 8'h00; end
                    else mode_val = bus_wdata & mode_mask;
                end else if (bus_addr[7:0] == 8'h01 && bus_addr >= 16'h0400) begin
                    cmd_left = cmd_reads; cmd_val = bus_wdata;
                end
            end else begin
                if (bus_addr == 16'h0000) begin
                    if (rst_cnt > 0) begin rst_cnt--; bus_rdata = 8'h80; end
                    else bus_rdata = mode_val;
                end else if (bus_addr == 16'h001F) bus_rdata = (dev == 2) ? 8'd3 : 8'd0;
                else if (bus_addr == 16'h0039) bus_rdata = (dev == 3) ? 8'd4 : 8'd0;
                else if (bus_addr[7:0] == 8'h01 && bus_addr >= 16'h0400) begin
                    if (cmd_left > 0) begin cmd_left--; bus_rdata = cmd_val; end
                end
            end
            if (!bus_we && bus_addr == 16'h0000) begin
                rd0_n++;
                if (rd0_n == 1) rd0_first = cyc;
                if (rd0_n == 20) rd0_20 = cyc;
            end
            bus_ack = 1'b1;
        end
    end

    task automatic do_reset(input int d, input int slow, input logic [7:0] mask);
        rst = 1'b1;
        q.delete();
        dev = d; rst_slow = slow; mode_mask = mask; mode_val = 8'h00;
        rst_cnt = 0; cmd_left = 0; rd0_n = 0; first_req = -1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rel_cyc = cyc;
    endtask

    task automatic exp_srst(input logic [1:0] f, input int nz, output bit ok);
        push(1, 16'h0000, 8'h80, f);
        ok = (nz < RPOLLS);
        for (int i = 0; i < (ok ? nz + 1 : RPOLLS); i++) push(0, 16'h0000, 8'h00, f);
    endtask

    task automatic exp_pat(input logic [1:0] f, input logic [23:0] p, input logic [7:0] mask, output bit ok);
        ok = 1;
        for (int i = 0; i < 3 && ok; i++) begin
            logic [7:0] v;
            v = p[23-8*i -: 8];
            push(1, 16'h0000, v, f);
            push(0, 16'h0000, 8'h00, f);
            if ((v & mask) != v) ok = 0;
        end
    endtask

    task automatic wait_done(input string rq);
        int n = 0;
        while (!det_done && n < 5000) begin @(negedge clk); n++; end
        chk(det_done, rq, 64'(det_done), 64'd1);
        repeat (2) @(negedge clk);
        chk(q.size() == 0, rq, 64'(q.size()), 64'd0);
    endtask

    task automatic chk_layout(input string rq, input logic [1:0] t, input logic [15:0] rb,
                              input logic [15:0] tb, input logic [15:0] rxb);
        chk(det_found == 1'b1 && det_type == t, rq, {det_found, det_type}, {1'b1, t});
        chk(reg_base == rb, rq, 64'(reg_base), 64'(rb));
        chk(buf_size == 16'd2048 && buf_mask == 16'h07FF, "R7/R8/R9 size", {buf_size, buf_mask}, {16'd2048, 16'h07FF});
        for (int i = 0; i < NS; i++) begin
            chk(tx_flat[16*i +: 16] == tb + 16'(2048 * i), "R11 tx base", 64'(tx_flat[16*i +: 16]), 64'(tb + 16'(2048 * i)));
            chk(rx_flat[16*i +: 16] == rxb + 16'(2048 * i), "R11 rx base", 64'(rx_flat[16*i +: 16]), 64'(rxb + 16'(2048 * i)));
        end
    endtask

    task automatic run_cmd(input logic [1:0] s, input logic [7:0] c, input int nz, input bit exp_err, input string rq);
        int n = 0;
        cmd_reads = nz;
        push(1, 16'h4000 + {6'h0, s, 8'h01}, c, 2'd2);
        for (int i = 0; i < ((nz < CPOLLS) ? nz + 1 : CPOLLS); i++) push(0, 16'h4000 + {6'h0, s, 8'h01}, 8'h00, 2'd2);
        cmd_sock = s; cmd_code = c; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R14: second request while busy must be dropped
        cmd_sock = 2'd2; cmd_code = 8'h77; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_done && n < 500) begin @(negedge clk); n++; end
        chk(cmd_done == 1'b1, rq, 64'(cmd_done), 64'd1);
        chk(cmd_err == exp_err, rq, 64'(cmd_err), 64'(exp_err));
        repeat (6) @(negedge clk);
        chk(q.size() == 0 && !cmd_busy, "R14 no extra command", 64'(q.size()), 64'd0);
    endtask

    initial begin
        bit ok;
        bus_ack = 1'b0; bus_rdata = 8'h00;
        cmd_valid = 1'b0; cmd_sock = 2'd0; cmd_code = 8'h00;

        // Framed device, fast reset
        do_reset(2, 0, 8'hFF);
        @(negedge clk);
        chk(!det_done && !det_found && !bus_req && det_type == 2'd0, "R10 reset state",
            {det_done, det_found, bus_req}, 64'd0);
        exp_srst(2, 0, ok);
        exp_pat(2, 24'h081000, 8'hFF, ok);
        push(0, 16'h001F, 8'h00, 2);
        for (int s = 0; s < 8; s++) begin
            push(1, 16'h4000 + 16'(s * 256) + 16'h1E, (s < NS) ? 8'd2 : 8'd0, 2);
            push(1, 16'h4000 + 16'(s * 256) + 16'h1F, (s < NS) ? 8'd2 : 8'd0, 2);
        end
        wait_done("R7 framed match");
        chk(first_req - rel_cyc >= STARTUP && first_req - rel_cyc <= STARTUP + 1, "R1 start-up wait",
            64'(first_req - rel_cyc), 64'(STARTUP));
        chk_layout("R7 framed layout", 2'd2, 16'h4000, 16'h8000, 16'hC000);
        chk(fam_sel == 2'd2, "R2 fam_sel after done", 64'(fam_sel), 64'd2);
        run_cmd(2'd1, 8'h20, 3, 1'b0, "R12 command completes");
        run_cmd(2'd3, 8'h10, 100, 1'b1, "R13 command timeout");

        // Block device, slow soft reset; R14 request during detection
        do_reset(3, 3, 8'hFF);
        exp_srst(2, 3, ok); exp_pat(2, 24'h081000, 8'hFF, ok); push(0, 16'h001F, 8'h00, 2);
        exp_srst(3, 3, ok); exp_pat(3, 24'h081000, 8'hFF, ok); push(0, 16'h0039, 8'h00, 3);
        repeat (5) @(negedge clk);
        cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk);
        chk(!cmd_busy, "R14 ignored before detection", 64'(cmd_busy), 64'd0);
        wait_done("R5/R8 block match");
        chk_layout("R8 block layout", 2'd3, 16'h1000, 16'h8000, 16'hC000);

        // Legacy device without mode bit 3
        do_reset(1, 0, 8'hF7);
        exp_srst(2, 0, ok); exp_pat(2, 24'h081000, 8'hF7, ok);
        exp_srst(3, 0, ok); exp_pat(3, 24'h081000, 8'hF7, ok);
        exp_srst(1, 0, ok); exp_pat(1, 24'h101200, 8'hF7, ok);
        push(1, 16'h001B, 8'h55, 1);
        push(1, 16'h001A, 8'h55, 1);
        wait_done("R4/R6/R9 legacy match");
        chk_layout("R9 legacy layout", 2'd1, 16'h0400, 16'h4000, 16'h6000);

        // Absent device
        do_reset(0, 0, 8'hFF);
        exp_srst(2, 99, ok); exp_srst(3, 99, ok); exp_srst(1, 99, ok);
        wait_done("R3/R10 no device");
        chk(!det_found && det_type == 2'd0 && reg_base == 16'h0 && buf_size == 16'h0 && tx_flat == '0,
            "R10 not found outputs", {det_found, det_type, reg_base}, 64'd0);
        chk(rd0_20 - rd0_first >= 19 * GAP, "R3 poll spacing", 64'(rd0_20 - rd0_first), 64'(19 * GAP));
        cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!cmd_busy && q.size() == 0, "R14 no command when not found", 64'(cmd_busy), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule